// File: doc/BRIEF.md
# Ones-Count Compare and Select

This block takes two 16-bit words and forwards whichever one holds more set bits. A tie goes to the first word, A. A two-bit flag reports which word was forwarded. It is a small steering element for datapaths that favour the denser of two candidates, for example a mask or a vote vector.

Each operand passes through its own bit-counting tree. The tree starts with full adders that collapse groups of three equal-weight bits into a two-bit count. Adder stages built from the same full-adder cell then merge neighbouring partial counts until one 5-bit total (0 to 16) remains for each operand. A magnitude comparator decides between the two totals and steers a 2:1 word multiplexer.

The block is purely combinational, with no clock, reset or storage. Both outputs follow the inputs within the same evaluation.

Top module: `ones_pick`

## Requirements
- R1: `pick_o` always equals `a_i` or `b_i`, never a blend of the two.
- R2: When the number of 1 bits in `a_i` is greater than the number in `b_i`, `pick_o` equals `a_i` and `sel_o` equals 2'b01.
- R3: When `a_i` has fewer 1 bits than `b_i`, `pick_o` equals `b_i` and `sel_o` equals 2'b00.
- R4: `sel_o` is two bits wide and its upper bit is always 0. Value 2'b01 means A was chosen and 2'b00 means B was chosen.
- R5: Equal counts select A with `sel_o` = 2'b01. This covers identical operands, both operands all zeros, and different words with the same count.
- R6: Each internal count is 5 bits wide and holds values 0 to 16 without wrapping. An all-ones operand (16) beats an operand with a single set bit, and two all-ones operands tie toward A.
- R7: Both outputs respond to an input change without any clock edge.
- R8: With `a_i` = 16'h2222 (4 ones) and `b_i` = 16'hAAAA (8 ones), `pick_o` = 16'hAAAA and `sel_o` = 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand; wins ties |
| b_i | input | 16 | Second operand |
| pick_o | output | 16 | The operand with the larger ones count |
| sel_o | output | 2 | 2'b01 when A was forwarded, 2'b00 when B was forwarded |

## Verification
The block holds no state, so a faulty carry or sum inside a counting tree shows up at the ports as soon as the inputs change. It appears as the wrong operand chosen, but only when the corrupted count crosses the other operand's count. This is why the stimulus concentrates on ties and near-ties, such as rotated copies of the same word and counts one apart. A count that wrapped at 16 would only be visible with an all-ones operand, so those vectors are applied on purpose. A wrong tie rule shows only when the counts are exactly equal, and then `sel_o` reverses.

// File: rtl/ones_pick_pkg.sv
package ones_pick_pkg;

  // Flag encoding for the chosen operand; upper bit is always zero.
  typedef enum logic [1:0] {
    PICK_B = 2'b00,
    PICK_A = 2'b01
  } pick_e;

  // Bits needed to hold a count from 0 up to w inclusive.
  function automatic int tally_w(input int w);
    return $clog2(w + 1);
  endfunction

endpackage

// File: rtl/ones_fa.sv
module ones_fa (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic c
);

  // Three equal-weight inputs -> two-bit count {c, s}.
  assign s = x ^ y ^ z;
  assign c = (x & y) | (x & z) | (y & z);

endmodule

// File: rtl/ones_rca.sv
module ones_rca #(
  parameter int N = 5
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] sum
);

  logic [N-1:0] cy;

  assign cy[0] = 1'b0;

  // The result always fits in N bits, so the top stage needs no carry out.
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (i < N - 1) begin : g_fa
      ones_fa u_fa (
        .x(a[i]),
        .y(b[i]),
        .z(cy[i]),
        .s(sum[i]),
        .c(cy[i+1])
      );
    end else begin : g_top
      assign sum[i] = a[i] ^ b[i] ^ cy[i];
    end
  end

endmodule

// File: rtl/ones_tally.sv
module ones_tally
  import ones_pick_pkg::*;
#(
  parameter  int W  = 16,
  localparam int CW = tally_w(W)
) (
  input  logic [W-1:0]  bits,
  output logic [CW-1:0] count
);

  if (W == 1) begin : g_leaf1
    assign count = bits;
  end else if (W <= 3) begin : g_leaf3
    // Leaf: a single full adder counts up to three equal-weight bits.
    logic [2:0] trio;
    assign trio = 3'(bits);
    ones_fa u_fa (
      .x(trio[0]),
      .y(trio[1]),
      .z(trio[2]),
      .s(count[0]),
      .c(count[1])
    );
  end else begin : g_split
    localparam int WL = W / 2;
    localparam int WH = W - WL;
    localparam int CL = tally_w(WL);
    localparam int CH = tally_w(WH);

    logic [CL-1:0] cnt_lo;
    logic [CH-1:0] cnt_hi;
    logic [CW-1:0] ext_lo;
    logic [CW-1:0] ext_hi;

    ones_tally #(.W(WL)) u_lo (
      .bits (bits[WL-1:0]),
      .count(cnt_lo)
    );

    ones_tally #(.W(WH)) u_hi (
      .bits (bits[W-1:WL]),
      .count(cnt_hi)
    );

    assign ext_lo = CW'(cnt_lo);
    assign ext_hi = CW'(cnt_hi);

    ones_rca #(.N(CW)) u_merge (
      .a  (ext_lo),
      .b  (ext_hi),
      .sum(count)
    );
  end

endmodule

// File: rtl/ones_pick_mux.sv
module ones_pick_mux
  import ones_pick_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = 5
) (
  input  logic [CW-1:0] cnt_a,
  input  logic [CW-1:0] cnt_b,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic [W-1:0]  pick,
  output pick_e         sel
);

  logic a_wins;

  // Ties favour A.
  assign a_wins = (cnt_a >= cnt_b);
  assign pick   = a_wins ? a : b;
  assign sel    = a_wins ? PICK_A : PICK_B;

endmodule

// File: rtl/ones_pick.sv
module ones_pick
  import ones_pick_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] pick_o,
  output logic [1:0]   sel_o
);

  localparam int CW = tally_w(W);

  logic [CW-1:0] cnt_a;
  logic [CW-1:0] cnt_b;
  pick_e         sel;

  ones_tally #(.W(W)) u_tally_a (
    .bits (a_i),
    .count(cnt_a)
  );

  ones_tally #(.W(W)) u_tally_b (
    .bits (b_i),
    .count(cnt_b)
  );

  ones_pick_mux #(.W(W), .CW(CW)) u_mux (
    .cnt_a(cnt_a),
    .cnt_b(cnt_b),
    .a    (a_i),
    .b    (b_i),
    .pick (pick_o),
    .sel  (sel)
  );

  assign sel_o = sel;

endmodule

// File: rtl/ones_pick_chk.sv
module ones_pick_chk
  import ones_pick_pkg::*;
#(
  parameter  int W  = 16,
  localparam int CW = tally_w(W)
) (
  input logic [W-1:0]  a_i,
  input logic [W-1:0]  b_i,
  input logic [W-1:0]  pick_o,
  input logic [1:0]    sel_o,
  input logic [CW-1:0] cnt_a,
  input logic [CW-1:0] cnt_b
);

  int pop_a;
  int pop_b;

  always_comb begin
    pop_a = $countones(a_i);
    pop_b = $countones(b_i);
    AST_IS_OPERAND: assert (pick_o == a_i || pick_o == b_i) else $error("output is not an operand"); // R1
    AST_A_WINS: assert (!(pop_a > pop_b) || (pick_o == a_i && sel_o == 2'b01)) else $error("A should win"); // R2
    AST_B_WINS: assert (!(pop_a < pop_b) || (pick_o == b_i && sel_o == 2'b00)) else $error("B should win"); // R3
    AST_FLAG_HI_ZERO: assert (sel_o[1] == 1'b0) else $error("flag upper bit set"); // R4
    AST_TIE_TO_A: assert (!(pop_a == pop_b) || sel_o == 2'b01) else $error("tie not given to A"); // R5
    AST_TALLY_A: assert (int'(cnt_a) == pop_a) else $error("count A wrong"); // R6
    AST_TALLY_B: assert (int'(cnt_b) == pop_b) else $error("count B wrong"); // R6
  end

endmodule

bind ones_pick ones_pick_chk #(.W(W)) u_chk (
  .a_i   (a_i),
  .b_i   (b_i),
  .pick_o(pick_o),
  .sel_o (sel_o),
  .cnt_a (cnt_a),
  .cnt_b (cnt_b)
);

// File: tb/ones_pick_bench.sv
module ones_pick_bench;

  typedef struct {
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] exp_out;
    logic [1:0]  exp_sel;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic [15:0] a_in = '0;
  logic [15:0] b_in = '0;
  logic [15:0] pick_o;
  logic [1:0]  sel_o;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  item_t sb[$];
  item_t cur;

  always #10 clk = ~clk;

  ones_pick u_ones_pick (
    .a_i   (a_in),
    .b_i   (b_in),
    .pick_o(pick_o),
    .sel_o (sel_o)
  );

  function automatic int ones(input logic [15:0] v);
    int n = 0;
    for (int i = 0; i < 16; i++) n += int'(v[i]);
    return n;
  endfunction

  // Driver: applies a vector and queues the expected result.
  task automatic apply(input logic [15:0] a, input logic [15:0] b, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    a_in = a;
    b_in = b;
    it.a = a;
    it.b = b;
    it.tag = tag;
    if (ones(a) >= ones(b)) begin
      it.exp_out = a;
      it.exp_sel = 2'b01;
    end else begin
      it.exp_out = b;
      it.exp_sel = 2'b00;
    end
    sb.push_back(it);
  endtask

  // Monitor: compares mid-cycle, away from the driving edge.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      cur = sb.pop_front();
      checks++;
      if (pick_o !== cur.exp_out || sel_o !== cur.exp_sel) begin
        fails++;
        $display("FAIL %s: a=%h b=%h actual out=%h sel=%b expected out=%h sel=%b",
                 cur.tag, cur.a, cur.b, pick_o, sel_o, cur.exp_out, cur.exp_sel);
      end
    end
  end

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    logic [15:0] ra;
    logic [15:0] rb;
    apply(16'h0000, 16'h0000, "R5 all zeros tie");
    apply(16'h2222, 16'hAAAA, "R8 worked example");
    apply(16'hAAAA, 16'h2222, "R2 A denser");
    apply(16'hFFFF, 16'hFFFF, "R5 R6 all ones tie");
    apply(16'hFFFF, 16'h0001, "R6 count 16 must not wrap");
    apply(16'h0001, 16'hFFFF, "R6 count 16 on B");
    apply(16'h7FFF, 16'hFFFF, "R3 fifteen vs sixteen");
    apply(16'h0000, 16'h0001, "R3 zero vs one");
    apply(16'h0001, 16'h8000, "R5 tie distinct words");
    apply(16'h1234, 16'h1234, "R5 identical");
    apply(16'hFFFF, 16'h0000, "R2 full vs empty");
    for (int k = 0; k < 300; k++) begin
      ra = 16'($urandom);
      rb = (k % 3 == 0) ? {ra[0], ra[15:1]} : 16'($urandom);
      apply(ra, rb, (k % 3 == 0) ? "R5 rotated tie" : "R1 R2 R3 R4 random");
    end
    @(posedge clk);
    wait (sb.size() == 0);
    // R7: inputs change mid-cycle, outputs checked before the next edge.
    @(negedge clk);
    #2;
    a_in = 16'h0F0F;
    b_in = 16'hF000;
    #1;
    checks++;
    if (pick_o !== 16'h0F0F || sel_o !== 2'b01) begin
      fails++;
      $display("FAIL R7: actual out=%h sel=%b expected out=0f0f sel=01", pick_o, sel_o);
    end
    b_in = 16'hFFF0;
    #1;
    checks++;
    if (pick_o !== 16'hFFF0 || sel_o !== 2'b00) begin
      fails++;
      $display("FAIL R7: actual out=%h sel=%b expected out=fff0 sel=00", pick_o, sel_o);
    end
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

endmodule